// File: doc/BRIEF.md
# Interrupt Mask and Arbitration Unit

This block decides when a small 8-bit processor core leaves its instruction stream to service an interrupt. It holds the interrupt-disable flag, forces the constant-one position of the status byte, latches falling edges on the non-maskable line, and samples the level-sensitive maskable request. At each instruction boundary it chooses the highest-priority source and presents one service request together with a vector selector. The selector stays fixed until the instruction sequencer acknowledges it.

When the optional start-up guard is enabled, reset sets a guard bit. While the guard bit is 1, a latched non-maskable event is held back rather than serviced. Initialisation code writes the guard bit to 0 once its vectors and peripherals are ready. Any event that arrived during start-up is then serviced at the next boundary. Instruction decode, stack pushes and the memory fetch of the vector belong to the surrounding core.

Top module: `intr_accept_unit`

## Requirements
- R1: Bit 5 of `status_o` reads 1 in every cycle, whatever `status_i` holds.
- R2: A cycle with `rst` high sets the interrupt-disable flag (`status_o[2]`) to 1 and clears `req_o`. At the first later boundary, the unit requests the start-up vector, with `vec_o` = 2'b00.
- R3: A `sei_i` strobe sets `status_o[2]` to 1 on the next cycle. A `cli_i` strobe without `sei_i` clears it to 0 on the next cycle.
- R4: When `ack_i` is high while `req_o` shows the maskable or non-maskable vector, `status_o[2]` reads 1 on the next cycle, even if `cli_i` is strobed in the same cycle.
- R5: A low `irq_n_i` is accepted at a boundary only while `status_o[2]` is 0. It is then requested with `vec_o` = 2'b10. While the flag is 1, a boundary with `irq_n_i` low leaves `req_o` low.
- R6: A pending non-maskable event is requested with `vec_o` = 2'b01 regardless of `status_o[2]`.
- R7: With `GUARD_EN`=1, reset sets `guard_o` to 1. A `guard_we_i` strobe loads `guard_d_i` into `guard_o`. While `guard_o` is 1, no non-maskable request is raised, but the latched event is kept. It is requested at the first boundary after `guard_o` returns to 0.
- R8: Only a high-to-low transition of `nmi_n_i` creates a pending event. A line that stays low after its event has been acknowledged raises no further request.
- R9: When several sources are eligible at one boundary, the start-up vector wins over the non-maskable one, and the non-maskable one wins over the maskable one.
- R10: `req_o` rises only in the cycle after `boundary_i` was high. Once raised, `req_o` and `vec_o` hold until the cycle after `ack_i`.
- R11: Bits 7, 6, 4, 3, 1 and 0 of `status_o` equal the same bits of `status_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also triggers the start-up request |
| irq_n_i | input | 1 | Maskable request, active-low level |
| nmi_n_i | input | 1 | Non-maskable request, active-low, falling-edge sensitive |
| sei_i | input | 1 | Strobe that sets the interrupt-disable flag |
| cli_i | input | 1 | Strobe that clears the interrupt-disable flag |
| boundary_i | input | 1 | Instruction boundary; sources are sampled only here |
| ack_i | input | 1 | Sequencer accepts the current request |
| guard_we_i | input | 1 | Write strobe for the start-up guard bit |
| guard_d_i | input | 1 | Value written to the guard bit |
| status_i | input | 8 | Status bits owned by the rest of the core |
| req_o | output | 1 | Service request |
| vec_o | output | 2 | Vector selector: 00 start-up, 01 non-maskable, 10 maskable |
| status_o | output | 8 | Merged status byte |
| guard_o | output | 1 | Current start-up guard bit |

## Verification
`status_o` is combinational, so it follows `status_i` in the same cycle. It follows a change of the disable flag one clock edge after the strobe or acknowledge. `req_o`, `vec_o` and `guard_o` are registered and change at the first edge after the boundary, acknowledge or write that causes them. A non-maskable edge must already be latched one edge before the boundary that services it. The bench drives inputs just after a falling clock edge. It queues the expected values for the next rising edge, and a monitor compares them at the falling edge that follows, so each check lands exactly one registered stage after its stimulus.

// File: rtl/intr_pkg.sv
package intr_pkg;

    localparam int STAT_W   = 8;
    localparam int IDIS_POS = 2;
    localparam int ONE_POS  = 5;

    typedef enum logic [1:0] {
        VEC_START = 2'b00,
        VEC_NMI   = 2'b01,
        VEC_IRQ   = 2'b10
    } vec_e;

    typedef struct packed {
        logic start;
        logic nmi;
        logic irq;
    } src_t;

    function automatic logic any_src(src_t s);
        return s.start | s.nmi | s.irq;
    endfunction

    function automatic vec_e pick_vec(src_t s);
        if (s.start)    return VEC_START;
        else if (s.nmi) return VEC_NMI;
        else            return VEC_IRQ;
    endfunction

    function automatic logic [STAT_W-1:0] merge_status(logic [STAT_W-1:0] ext, logic idis);
        logic [STAT_W-1:0] r;
        r = ext;
        r[IDIS_POS] = idis;
        r[ONE_POS]  = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/intr_nmi_edge.sv
module intr_nmi_edge (
    input  logic clk,
    input  logic rst,
    input  logic nmi_n_i,
    input  logic taken_i,
    output logic pend_o
);
    logic line_q;
    logic fall;

    assign fall = line_q & ~nmi_n_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b1;
            pend_o <= 1'b0;
        end else begin
            line_q <= nmi_n_i;
            if (fall)         pend_o <= 1'b1;
            else if (taken_i) pend_o <= 1'b0;
        end
    end

    p_edge_latch_r8: assert property (@(posedge clk) disable iff (rst)
        fall |=> pend_o);

    p_no_spont_r8: assert property (@(posedge clk) disable iff (rst)
        (!pend_o && !fall) |=> !pend_o);
endmodule

// File: rtl/intr_mask_flags.sv
module intr_mask_flags #(
    parameter bit GUARD_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sei_i,
    input  logic cli_i,
    input  logic svc_i,
    input  logic guard_we_i,
    input  logic guard_d_i,
    output logic idis_o,
    output logic guard_o
);
    always_ff @(posedge clk) begin
        if (rst)        idis_o <= 1'b1;
        else if (svc_i) idis_o <= 1'b1;
        else if (sei_i) idis_o <= 1'b1;
        else if (cli_i) idis_o <= 1'b0;
    end

    generate
        if (GUARD_EN) begin : g_guard
            always_ff @(posedge clk) begin
                if (rst)             guard_o <= 1'b1;
                else if (guard_we_i) guard_o <= guard_d_i;
            end
        end else begin : g_noguard
            assign guard_o = 1'b0;
        end
    endgenerate

    p_sei_sets_r3: assert property (@(posedge clk) disable iff (rst)
        sei_i |=> idis_o);

    p_cli_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (cli_i && !sei_i && !svc_i) |=> !idis_o);

    p_svc_masks_r4: assert property (@(posedge clk) disable iff (rst)
        svc_i |=> idis_o);
endmodule

// File: rtl/intr_select.sv
module intr_select
    import intr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic boundary_i,
    input  logic ack_i,
    input  logic nmi_pend_i,
    input  logic irq_n_i,
    input  logic idis_i,
    input  logic guard_i,
    output logic req_o,
    output vec_e vec_o,
    output logic take_nmi_o,
    output logic svc_o
);
    logic start_pend;
    src_t cand;
    logic fire;

    always_comb begin
        cand.start = start_pend;
        cand.nmi   = nmi_pend_i & ~guard_i;
        cand.irq   = ~irq_n_i & ~idis_i;
    end

    assign fire       = req_o & ack_i;
    assign take_nmi_o = fire & (vec_o == VEC_NMI);
    assign svc_o      = fire & (vec_o != VEC_START);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_pend <= 1'b1;
            req_o      <= 1'b0;
            vec_o      <= VEC_START;
        end else if (fire) begin
            req_o <= 1'b0;
            if (vec_o == VEC_START) start_pend <= 1'b0;
        end else if (!req_o && boundary_i && any_src(cand)) begin
            req_o <= 1'b1;
            vec_o <= pick_vec(cand);
        end
    end

    p_boundary_only_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |-> $past(boundary_i));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (req_o && !ack_i) |=> (req_o && $stable(vec_o)));

    p_irq_masked_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(req_o) && vec_o == VEC_IRQ) |-> !$past(idis_i));

    p_guard_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(req_o) && vec_o == VEC_NMI) |-> !$past(guard_i));

    p_nmi_over_irq_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(req_o) && $past(nmi_pend_i && !guard_i)) |-> vec_o != VEC_IRQ);
endmodule

// File: rtl/intr_accept_unit.sv
module intr_accept_unit
    import intr_pkg::*;
#(
    parameter bit GUARD_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_n_i,
    input  logic              nmi_n_i,
    input  logic              sei_i,
    input  logic              cli_i,
    input  logic              boundary_i,
    input  logic              ack_i,
    input  logic              guard_we_i,
    input  logic              guard_d_i,
    input  logic [STAT_W-1:0] status_i,
    output logic              req_o,
    output logic [1:0]        vec_o,
    output logic [STAT_W-1:0] status_o,
    output logic              guard_o
);
    logic nmi_pend;
    logic take_nmi;
    logic svc;
    logic idis;
    vec_e vec;

    intr_nmi_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .nmi_n_i (nmi_n_i),
        .taken_i (take_nmi),
        .pend_o  (nmi_pend)
    );

    intr_mask_flags #(.GUARD_EN(GUARD_EN)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .sei_i      (sei_i),
        .cli_i      (cli_i),
        .svc_i      (svc),
        .guard_we_i (guard_we_i),
        .guard_d_i  (guard_d_i),
        .idis_o     (idis),
        .guard_o    (guard_o)
    );

    intr_select u_sel (
        .clk        (clk),
        .rst        (rst),
        .boundary_i (boundary_i),
        .ack_i      (ack_i),
        .nmi_pend_i (nmi_pend),
        .irq_n_i    (irq_n_i),
        .idis_i     (idis),
        .guard_i    (guard_o),
        .req_o      (req_o),
        .vec_o      (vec),
        .take_nmi_o (take_nmi),
        .svc_o      (svc)
    );

    assign vec_o    = vec;
    assign status_o = merge_status(status_i, idis);

    p_start_masked_r2: assert property (@(posedge clk)
        rst |=> (status_o[IDIS_POS] && !req_o));
endmodule

// File: tb/test_intr_accept_unit.sv
module test_intr_accept_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       irq_n = 1'b1, nmi_n = 1'b1;
    logic       sei = 1'b0, cli = 1'b0, bnd = 1'b0, ack = 1'b0;
    logic       gwe = 1'b0, gd = 1'b0;
    logic [7:0] st_in = 8'h00;
    logic       req;
    logic [1:0] vec;
    logic [7:0] st_out;
    logic       grd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct packed {
        logic       req;
        logic [1:0] vec;
        logic [7:0] st;
        logic       grd;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];

    always #5 clk = ~clk;

    intr_accept_unit #(.GUARD_EN(1'b1)) i_intr_accept_unit (
        .clk(clk), .rst(rst), .irq_n_i(irq_n), .nmi_n_i(nmi_n),
        .sei_i(sei), .cli_i(cli), .boundary_i(bnd), .ack_i(ack),
        .guard_we_i(gwe), .guard_d_i(gd), .status_i(st_in),
        .req_o(req), .vec_o(vec), .status_o(st_out), .guard_o(grd)
    );

    function automatic logic [7:0] mk_st(logic [7:0] ext, logic i);
        logic [7:0] r;
        r = ext;
        r[2] = i;
        r[5] = 1'b1;
        return r;
    endfunction

    task automatic expect_after(logic r, logic [1:0] v, logic i, logic g, string tag);
        exp_t e;
        e.req = r; e.vec = v; e.st = mk_st(st_in, i); e.grd = g;
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
        sei = 0; cli = 0; ack = 0; gwe = 0; bnd = 0;
    endtask

    // monitor: compares queued items at the falling edge
    always @(negedge clk) begin
        while (q_exp.size() > 0) begin
            exp_t  e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (req !== e.req || (e.req && vec !== e.vec) || st_out !== e.st || grd !== e.grd) begin
                errors++;
                $display("FAIL %s: got req=%0b vec=%02b st=%02h grd=%0b exp req=%0b vec=%02b st=%02h grd=%0b",
                         t, req, vec, st_out, grd, e.req, e.vec, e.st, e.grd);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hang exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); #1;
        // R2 R1 R7: reset state
        expect_after(0, 2'b00, 1, 1, "R2 reset state");
        tick();
        rst = 0; st_in = 8'hC3;
        // R11 R1 R10: passthrough, no request without boundary
        expect_after(0, 2'b00, 1, 1, "R11 R10 passthrough idle");
        tick();
        bnd = 1;
        expect_after(1, 2'b00, 1, 1, "R2 start vector");
        tick();
        expect_after(1, 2'b00, 1, 1, "R10 hold until ack");
        tick();
        ack = 1;
        expect_after(0, 2'b00, 1, 1, "R10 cleared by ack");
        tick();
        // R5: masked irq
        irq_n = 0; bnd = 1;
        expect_after(0, 2'b00, 1, 1, "R5 irq masked");
        tick();
        cli = 1; st_in = 8'hDF;
        expect_after(0, 2'b00, 0, 1, "R3 cli clears R1");
        tick();
        bnd = 1;
        expect_after(1, 2'b10, 0, 1, "R5 irq accepted");
        tick();
        ack = 1; cli = 1;
        expect_after(0, 2'b00, 1, 1, "R4 ack sets mask");
        tick();
        irq_n = 1; cli = 1;
        expect_after(0, 2'b00, 0, 1, "R3 cli");
        tick();
        sei = 1;
        expect_after(0, 2'b00, 1, 1, "R3 sei");
        tick();
        // R7: guard blocks nmi
        nmi_n = 0;
        expect_after(0, 2'b00, 1, 1, "R7 nmi edge latched");
        tick();
        nmi_n = 1; bnd = 1;
        expect_after(0, 2'b00, 1, 1, "R7 guard holds nmi");
        tick();
        gwe = 1; gd = 0;
        expect_after(0, 2'b00, 1, 0, "R7 guard cleared");
        tick();
        bnd = 1;
        expect_after(1, 2'b01, 1, 0, "R6 R7 nmi serviced with mask set");
        tick();
        ack = 1;
        expect_after(0, 2'b00, 1, 0, "R7 nmi ack");
        tick();
        // R8: level low yields one service
        nmi_n = 0;
        expect_after(0, 2'b00, 1, 0, "R8 edge");
        tick();
        bnd = 1;
        expect_after(1, 2'b01, 1, 0, "R8 request");
        tick();
        ack = 1;
        expect_after(0, 2'b00, 1, 0, "R8 ack");
        tick();
        bnd = 1;
        expect_after(0, 2'b00, 1, 0, "R8 held low no retrigger");
        tick();
        // R9: nmi over irq
        nmi_n = 1; cli = 1;
        expect_after(0, 2'b00, 0, 0, "R9 setup");
        tick();
        nmi_n = 0; irq_n = 0;
        expect_after(0, 2'b00, 0, 0, "R9 edge");
        tick();
        bnd = 1;
        expect_after(1, 2'b01, 0, 0, "R9 nmi wins over irq");
        tick();
        ack = 1;
        expect_after(0, 2'b00, 1, 0, "R9 R4 ack nmi sets mask");
        tick();
        irq_n = 1; nmi_n = 1;
        // R9: start vector over nmi
        rst = 1;
        expect_after(0, 2'b00, 1, 1, "R2 re-reset");
        tick();
        rst = 0; gwe = 1; gd = 0; nmi_n = 0;
        expect_after(0, 2'b00, 1, 0, "R7 guard write after reset");
        tick();
        bnd = 1;
        expect_after(1, 2'b00, 1, 0, "R9 start wins over nmi");
        tick();
        ack = 1;
        expect_after(0, 2'b00, 1, 0, "R9 start ack");
        tick();
        bnd = 1;
        expect_after(1, 2'b01, 1, 0, "R9 nmi after start");
        tick();
        ack = 1;
        expect_after(0, 2'b00, 1, 0, "R9 final ack");
        tick();
        tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule